// File: doc/BRIEF.md
# Serial Control Channel Command Validator

This block sits behind the slot extractor of a time-multiplexed serial control bus. Once per frame it receives one 8-bit control byte, marked by a single-cycle frame strobe. Six of the byte's bits form a command word. A new command word is accepted only after the same word has arrived in two consecutive frames. This keeps a single corrupted frame from reaching the line-control logic.

The filter holds two values. The first is the accepted (primary) command word. The second is a pending (secondary) candidate, which has a valid flag. When the command word changes, the block emits a one-clock change pulse. It also presents four decoded control flags from the accepted word, all from registers. The two handshake bits at the bottom of the byte belong to another channel and are ignored here.

Top module: `scc_cmd_validator`

## Requirements
- R1: After a synchronous active-high reset, the accepted word is 6'b000000, no candidate is pending, the change pulse is low and all four flags are low.
- R2: Byte bits 7..2 carry command bits 6..1, so the accepted word equals frame_byte[7:2]. Byte bits 1 and 0 are handshake bits and never affect any output. A frame whose bits 7..2 equal the accepted word, with no candidate pending, changes nothing.
- R3: A frame whose command word differs from the accepted word, with no candidate pending, is stored as the pending candidate. The accepted word does not change.
- R4: When a candidate is pending and the next frame carries the same command word, that word becomes the accepted word. It is visible on cmd_state in the cycle after the strobe, and the pending flag clears.
- R5: When a candidate is pending and the next frame's word differs from both the candidate and the accepted word, the new word replaces the candidate. The accepted word does not change. One more matching frame then promotes it.
- R6: When a candidate is pending and the next frame's word equals the accepted word, the candidate is discarded. The accepted word does not change, so a following single frame of the old candidate does not promote it.
- R7: Cycles with frame_vld low change no state and no output, whatever frame_byte holds. Two strobed frames count as consecutive even when idle cycles separate them.
- R8: cmd_changed is high for exactly one clock, in the cycle after a promotion that changes the accepted word. At all other times it is low.
- R9: The flags follow the accepted word with the same timing. off_hook is byte bit 2 (command bit 1), ring_cmd is byte bit 3, tone_gnd_det_en is byte bit 4, and onhook_mon is byte bit 5. Byte bits 7 and 6 are reserved and appear only in cmd_state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One-cycle strobe marking a received control byte |
| frame_byte | input | 8 | Received control channel byte |
| cmd_state | output | 6 | Accepted command word (command bits 6..1) |
| cmd_changed | output | 1 | One-clock pulse after the accepted word changes |
| off_hook | output | 1 | Decoded off-hook command |
| ring_cmd | output | 1 | Decoded ring command |
| tone_gnd_det_en | output | 1 | Decoded tone/ground-detect enable |
| onhook_mon | output | 1 | Decoded on-hook line monitor command |

## Verification
The bench sweeps every ordered pair of 6-bit command words (a, b), with a derived third word c, through the frame sequence a, a, b, a, b, c, c, b, b. This puts each pair through all of the filter's cases:
- a repeat of the accepted word;
- a first sighting that is only latched;
- a return to the old word that discards the candidate;
- a third word that replaces the candidate;
- a matching pair that promotes.

The handshake bits change from frame to frame, and idle gaps with junk on the byte input separate some frames. These show that neither has any effect and that pairing survives gaps. After every frame the bench compares the accepted word, the pulse and the flags against a model built from the requirements. On idle cycles it confirms that nothing moves.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int BYTE_W  = 8;
  localparam int CMD_LSB = 2;
  localparam int CMD_W   = BYTE_W - CMD_LSB;

  // positions of the decoded controls inside the command word
  localparam int IDX_OFFHOOK = 0;
  localparam int IDX_RING    = 1;
  localparam int IDX_TGDE    = 2;
  localparam int IDX_ONHM    = 3;

  typedef struct packed {
    logic onhm;
    logic tgde;
    logic ring;
    logic offhook;
  } ctl_flags_t;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_LATCH,
    EV_PROMOTE,
    EV_REPLACE,
    EV_DISCARD
  } filt_event_e;
endpackage

// File: rtl/scc_field_unpack.sv
module scc_field_unpack #(
  parameter int BYTE_W  = scc_pkg::BYTE_W,
  parameter int CMD_LSB = scc_pkg::CMD_LSB,
  localparam int CMD_W  = BYTE_W - CMD_LSB
) (
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CMD_W-1:0]  cmd_out
);
  logic unused_hs_bits;

  assign cmd_out        = byte_in[BYTE_W-1:CMD_LSB];
  assign unused_hs_bits = ^byte_in[CMD_LSB-1:0];
endmodule

// File: rtl/scc_pair_filter.sv
module scc_pair_filter
  import scc_pkg::*;
#(
  parameter int CMD_W = scc_pkg::CMD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_vld,
  input  logic [CMD_W-1:0] cmd_in,
  output logic [CMD_W-1:0] acc_q,
  output logic [CMD_W-1:0] acc_nxt,
  output logic             chg_q
);
  logic [CMD_W-1:0] pend_q, pend_nxt;
  logic             pv_q, pv_nxt;
  logic             hit_acc, hit_pend;
  filt_event_e      ev;

  assign hit_acc  = (cmd_in == acc_q);
  assign hit_pend = pv_q && (cmd_in == pend_q);

  always_comb begin
    ev = EV_NONE;
    if (frame_vld) begin
      if (!pv_q) begin
        ev = hit_acc ? EV_NONE : EV_LATCH;
      end else if (hit_pend) begin
        ev = EV_PROMOTE;
      end else if (hit_acc) begin
        ev = EV_DISCARD;
      end else begin
        ev = EV_REPLACE;
      end
    end
  end

  always_comb begin
    acc_nxt  = acc_q;
    pend_nxt = pend_q;
    pv_nxt   = pv_q;
    unique case (ev)
      EV_LATCH, EV_REPLACE: begin
        pend_nxt = cmd_in;
        pv_nxt   = 1'b1;
      end
      EV_PROMOTE: begin
        acc_nxt = pend_q;
        pv_nxt  = 1'b0;
      end
      EV_DISCARD: pv_nxt = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      pend_q <= '0;
      pv_q   <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      acc_q  <= acc_nxt;
      pend_q <= pend_nxt;
      pv_q   <= pv_nxt;
      chg_q  <= (ev == EV_PROMOTE) && (pend_q != acc_q);
    end
  end

  AST_PEND_NOT_ACC: assert property (@(posedge clk) disable iff (rst)
    pv_q |-> (pend_q != acc_q)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !frame_vld |=> ($stable(acc_q) && $stable(pend_q) && $stable(pv_q))); // R7
  AST_NEEDS_PAIR: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && !(pv_q && cmd_in == pend_q)) |=> $stable(acc_q)); // R4
  AST_DISCARD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && pv_q && cmd_in != pend_q && cmd_in == acc_q) |=> !pv_q); // R6
  AST_REPLACE_TAKES: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && pv_q && cmd_in != pend_q && cmd_in != acc_q)
      |=> (pv_q && pend_q == $past(cmd_in))); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    chg_q |=> !chg_q); // R8
endmodule

// File: rtl/scc_flag_decode.sv
module scc_flag_decode
  import scc_pkg::*;
#(
  parameter int CMD_W       = scc_pkg::CMD_W,
  parameter int IDX_OFFHOOK = scc_pkg::IDX_OFFHOOK,
  parameter int IDX_RING    = scc_pkg::IDX_RING,
  parameter int IDX_TGDE    = scc_pkg::IDX_TGDE,
  parameter int IDX_ONHM    = scc_pkg::IDX_ONHM
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] word_nxt,
  output ctl_flags_t       flags_q
);
  ctl_flags_t flags_d;

  always_comb begin
    flags_d.offhook = word_nxt[IDX_OFFHOOK];
    flags_d.ring    = word_nxt[IDX_RING];
    flags_d.tgde    = word_nxt[IDX_TGDE];
    flags_d.onhm    = word_nxt[IDX_ONHM];
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end
endmodule

// File: rtl/scc_cmd_validator.sv
module scc_cmd_validator
  import scc_pkg::*;
#(
  parameter int BYTE_W  = scc_pkg::BYTE_W,
  parameter int CMD_LSB = scc_pkg::CMD_LSB,
  localparam int CMD_W  = BYTE_W - CMD_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_vld,
  input  logic [BYTE_W-1:0] frame_byte,
  output logic [CMD_W-1:0]  cmd_state,
  output logic              cmd_changed,
  output logic              off_hook,
  output logic              ring_cmd,
  output logic              tone_gnd_det_en,
  output logic              onhook_mon
);
  logic [CMD_W-1:0] cmd_word;
  logic [CMD_W-1:0] acc_nxt;
  ctl_flags_t       flags;

  scc_field_unpack #(.BYTE_W(BYTE_W), .CMD_LSB(CMD_LSB)) u_unpack (
    .byte_in (frame_byte),
    .cmd_out (cmd_word)
  );

  scc_pair_filter #(.CMD_W(CMD_W)) u_filter (
    .clk       (clk),
    .rst       (rst),
    .frame_vld (frame_vld),
    .cmd_in    (cmd_word),
    .acc_q     (cmd_state),
    .acc_nxt   (acc_nxt),
    .chg_q     (cmd_changed)
  );

  scc_flag_decode #(.CMD_W(CMD_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .word_nxt (acc_nxt),
    .flags_q  (flags)
  );

  assign off_hook        = flags.offhook;
  assign ring_cmd        = flags.ring;
  assign tone_gnd_det_en = flags.tgde;
  assign onhook_mon      = flags.onhm;

  AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    cmd_changed |-> (cmd_state != $past(cmd_state))); // R8
  AST_CHANGE_MEANS_PULSE: assert property (@(posedge clk) disable iff (rst)
    (cmd_state != $past(cmd_state)) |-> cmd_changed); // R8
  AST_FLAGS_TRACK: assert property (@(posedge clk) disable iff (rst)
    (off_hook == cmd_state[IDX_OFFHOOK]) && (ring_cmd == cmd_state[IDX_RING])
      && (tone_gnd_det_en == cmd_state[IDX_TGDE]) && (onhook_mon == cmd_state[IDX_ONHM])); // R9
endmodule

// File: tb/sim_scc_cmd_validator.sv
module sim_scc_cmd_validator;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_vld = 1'b0;
  logic [7:0] frame_byte = 8'h00;
  logic [5:0] cmd_state;
  logic       cmd_changed, off_hook, ring_cmd, tone_gnd_det_en, onhook_mon;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] m_acc = '0, m_pend = '0;
  bit         m_pv = 1'b0, m_pulse = 1'b0;

  always #2 clk = ~clk;

  scc_cmd_validator u0 (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame_byte(frame_byte),
    .cmd_state(cmd_state), .cmd_changed(cmd_changed), .off_hook(off_hook),
    .ring_cmd(ring_cmd), .tone_gnd_det_en(tone_gnd_det_en), .onhook_mon(onhook_mon)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk(req, "off_hook", {7'd0, off_hook}, {7'd0, m_acc[0]});
    chk(req, "ring_cmd", {7'd0, ring_cmd}, {7'd0, m_acc[1]});
    chk(req, "tone_gnd_det_en", {7'd0, tone_gnd_det_en}, {7'd0, m_acc[2]});
    chk(req, "onhook_mon", {7'd0, onhook_mon}, {7'd0, m_acc[3]});
  endtask

  // model built from the requirement text; returns requirement tag
  function automatic string model_step(input logic [5:0] c);
    m_pulse = 1'b0;
    if (!m_pv) begin
      if (c == m_acc) return "R2";
      m_pend = c; m_pv = 1'b1; return "R3";
    end
    if (c == m_pend) begin
      m_pulse = (m_pend != m_acc);
      m_acc = m_pend; m_pv = 1'b0; return "R4";
    end
    if (c == m_acc) begin
      m_pv = 1'b0; return "R6";
    end
    m_pend = c; return "R5";
  endfunction

  task automatic send(input logic [5:0] c, input logic [1:0] hs, input int gap);
    string tag;
    @(negedge clk);
    frame_vld  = 1'b1;
    frame_byte = {c, hs};
    tag = model_step(c);
    @(negedge clk);
    frame_vld  = 1'b0;
    frame_byte = $urandom();
    chk(tag, "cmd_state", {2'b00, cmd_state}, {2'b00, m_acc});
    chk("R8", "cmd_changed", {7'd0, cmd_changed}, {7'd0, m_pulse});
    chk_flags("R9");
    for (int g = 0; g < gap; g++) begin
      frame_byte = $urandom();
      @(negedge clk);
      chk("R7", "cmd_state idle", {2'b00, cmd_state}, {2'b00, m_acc});
      chk("R8", "cmd_changed idle", {7'd0, cmd_changed}, 8'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset cmd_state", {2'b00, cmd_state}, 8'd0);
    chk("R1", "reset cmd_changed", {7'd0, cmd_changed}, 8'd0);
    chk("R1", "reset flags", {4'd0, onhook_mon, tone_gnd_det_en, ring_cmd, off_hook}, 8'd0);

    // directed: handshake bits only, then a promote with gap between pair
    send(6'h00, 2'b11, 0);            // R2: handshake bits ignored
    send(6'h2A, 2'b01, 2);            // R3 latch
    send(6'h2A, 2'b10, 1);            // R4 promote across gap (R7)
    send(6'h2A, 2'b00, 0);            // R2 repeat

    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        logic [5:0] c;
        logic [1:0] hs;
        c  = 6'(b) ^ 6'h15;
        hs = 2'(a + b);
        send(6'(a), hs, 0);
        send(6'(a), ~hs, (a + b) & 1);
        send(6'(b), hs, 0);
        send(6'(a), hs, 0);            // R6 discard when b differs
        send(6'(b), ~hs, 1);           // single frame after discard: no promote
        send(c, hs, 0);                // R5 replace (or latch)
        send(c, ~hs, 0);               // promote c
        send(6'(b), hs, (b & 1));
        send(6'(b), hs, 0);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule